// File: doc/BRIEF.md
# FEAC Codeword Transmit Sequencer

This block produces the serial far-end alarm and control stream that a DS3 transmit formatter places into its overhead. Two 6-bit code values, A and B, come from the register side together with a two-bit mode select and a one-cycle start strobe. For each codeword the block loads a 16-bit pattern and shifts it out one bit per line-side bit enable. Bursts run in one of four modes: nothing, ten codewords of A, ten of A followed at once by ten of B, or A repeated for as long as the continuous mode stays selected.

A start strobe is remembered until the next codeword boundary. A strobe that arrives mid-codeword never cuts that codeword short. The mode is captured when the burst begins. Both code inputs are read again at the start of every codeword. Whenever no codeword is in flight, the serial line rests at one. A busy flag spans from the strobe to the final bit of a finite burst, and a done flag marks a finite burst that ran to completion.

Top module: `feac_tx_seq`

## Requirements
- R1: After reset, serOut is 1, busy is 0 and done is 0.
- R2: While busy is 0, serOut is 1. A start strobe given with modeSel = 0 (idle) sends nothing.
- R3: Each codeword is sent as: a 0, then code bits 0 to 5 of the register in that order (bit 0 first), then a 0, then eight 1s.
- R4: With modeSel = 1 (single), a burst sends exactly ten codewords of codeA. After that, serOut returns to 1 and done is set.
- R5: With modeSel = 2 (dual), ten codewords of codeA are followed directly, with no gap, by ten codewords of codeB. After that, serOut returns to 1 and done is set.
- R6: With modeSel = 3 (continuous), codewords of codeA repeat without limit. When modeSel is not 3 at the last bit of a codeword, the burst stops at the end of that codeword and done is not set.
- R7: serOut and the sequencing state change only on clock edges where bitEn is 1.
- R8: A start strobe takes effect at the next codeword boundary. If a burst is running there, it is abandoned and a new burst begins with the mode present at that boundary. A change of modeSel during a single or dual burst is ignored.
- R9: codeA and codeB are sampled when each codeword begins. A change in the middle of a codeword appears only in the next codeword.
- R10: busy is 1 from the clock after a start strobe until the edge that emits the last bit of a finite burst. done is cleared when a new burst begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | Line-side bit enable; one output bit per enabled cycle |
| codeA | input | 6 | First code, bit 0 sent first |
| codeB | input | 6 | Second code, bit 0 sent first |
| modeSel | input | 2 | 0 idle, 1 single, 2 dual, 3 continuous |
| startPulse | input | 1 | One-cycle request to begin a burst |
| serOut | output | 1 | Serial FEAC stream |
| busy | output | 1 | Burst pending or in progress |
| done | output | 1 | Last finite burst completed |

## Verification
The bench builds the block with its default parameters: six code bits, eight fill ones and ten repeats per burst. These values keep full single and dual bursts to a few hundred enabled bits, so the bench can run every mode to completion. It can also hit the A-to-B handover and the final bit of a burst. It runs under bit-enable ratios from one in one to one in five, which exposes holding between enables. Restart, mode-change and code-change events are placed in the middle of codewords so that boundary sampling is exercised.

// File: rtl/feac_tx_pkg.sv
package feac_tx_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_SINGLE = 2'd1,
    MODE_DUAL   = 2'd2,
    MODE_CONT   = 2'd3
  } feac_mode_e;

  typedef struct packed {
    logic loadA;
    logic loadB;
    logic shift;
    logic fillOne;
  } feac_strobe_t;
endpackage

// File: rtl/feac_tx_datapath.sv
module feac_tx_datapath import feac_tx_pkg::*; #(
  parameter int CODE_W = 6,
  parameter int FILL_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  feac_strobe_t      strobe,
  input  logic [CODE_W-1:0] codeA,
  input  logic [CODE_W-1:0] codeB,
  output logic              serOut
);
  localparam int WORD_W = CODE_W + 2 + FILL_W;

  logic [CODE_W-1:0] codeSel;
  logic [WORD_W-1:0] wordNext;
  logic [WORD_W-2:0] shReg;

  assign codeSel  = strobe.loadB ? codeB : codeA;
  // bit 0 goes out first: leading 0, code bit 0..N-1, trailing 0, fill ones
  assign wordNext = {{FILL_W{1'b1}}, 1'b0, codeSel, 1'b0};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      serOut <= 1'b1;
      shReg  <= '1;
    end else if (strobe.loadA || strobe.loadB) begin
      serOut <= wordNext[0];
      shReg  <= wordNext[WORD_W-1:1];
    end else if (strobe.shift) begin
      serOut <= shReg[0];
      shReg  <= {1'b1, shReg[WORD_W-2:1]};
    end else if (strobe.fillOne) begin
      serOut <= 1'b1;
    end
  end
endmodule

// File: rtl/feac_tx_ctrl.sv
module feac_tx_ctrl import feac_tx_pkg::*; #(
  parameter int WORD_W = 16,
  parameter int REPS   = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         bitEn,
  input  logic [1:0]   modeSel,
  input  logic         startPulse,
  output feac_strobe_t strobe,
  output logic         busy,
  output logic         done
);
  localparam int IDX_W = $clog2(WORD_W);
  localparam int REP_W = $clog2(REPS + 1);

  feac_mode_e       modeNow;
  logic [IDX_W-1:0] bitIdx;
  logic [REP_W-1:0] repCnt;
  logic             running, contRun, dualRun, phaseB, pending;
  logic             atBoundary, lastBit, startNow;

  assign modeNow    = feac_mode_e'(modeSel);
  assign atBoundary = (bitIdx == '0);
  assign lastBit    = (bitIdx == IDX_W'(WORD_W - 1));
  assign startNow   = bitEn && atBoundary && pending;
  assign busy       = pending || running;

  always_comb begin
    strobe = '0;
    if (bitEn) begin
      if (!atBoundary) strobe.shift = 1'b1;
      else if (pending) begin
        if (modeNow != MODE_IDLE) strobe.loadA = 1'b1;
        else                      strobe.fillOne = 1'b1;
      end else if (running) begin
        if (contRun || (!phaseB && repCnt != REP_W'(REPS))) strobe.loadA = 1'b1;
        else                                                strobe.loadB = 1'b1;
      end else strobe.fillOne = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitIdx  <= '0;
      repCnt  <= '0;
      running <= 1'b0;
      contRun <= 1'b0;
      dualRun <= 1'b0;
      phaseB  <= 1'b0;
      pending <= 1'b0;
      done    <= 1'b0;
    end else begin
      pending <= startPulse || (pending && !startNow);
      if (bitEn) begin
        if (atBoundary) begin
          if (pending) begin
            running <= (modeNow != MODE_IDLE);
            contRun <= (modeNow == MODE_CONT);
            dualRun <= (modeNow == MODE_DUAL);
            phaseB  <= 1'b0;
            repCnt  <= REP_W'(1);
            done    <= 1'b0;
            bitIdx  <= (modeNow != MODE_IDLE) ? IDX_W'(1) : '0;
          end else if (running) begin
            bitIdx <= IDX_W'(1);
            if (strobe.loadB && !phaseB) begin
              phaseB <= 1'b1;
              repCnt <= REP_W'(1);
            end else if (!contRun) begin
              repCnt <= repCnt + REP_W'(1);
            end
          end
        end else begin
          bitIdx <= lastBit ? '0 : bitIdx + IDX_W'(1);
          if (lastBit && running) begin
            if (contRun) begin
              if (modeNow != MODE_CONT) running <= 1'b0;
            end else if (repCnt == REP_W'(REPS) && (phaseB || !dualRun)) begin
              running <= 1'b0;
              done    <= 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/feac_tx_seq.sv
module feac_tx_seq import feac_tx_pkg::*; #(
  parameter int CODE_W = 6,
  parameter int FILL_W = 8,
  parameter int REPS   = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic [CODE_W-1:0] codeA,
  input  logic [CODE_W-1:0] codeB,
  input  logic [1:0]        modeSel,
  input  logic              startPulse,
  output logic              serOut,
  output logic              busy,
  output logic              done
);
  localparam int WORD_W = CODE_W + 2 + FILL_W;

  feac_strobe_t strobe;

  feac_tx_ctrl #(.WORD_W(WORD_W), .REPS(REPS)) uCtrl (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .modeSel(modeSel),
    .startPulse(startPulse), .strobe(strobe), .busy(busy), .done(done)
  );

  feac_tx_datapath #(.CODE_W(CODE_W), .FILL_W(FILL_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .codeA(codeA),
    .codeB(codeB), .serOut(serOut)
  );
endmodule

// File: rtl/feac_tx_seq_checker.sv
module feac_tx_seq_checker (
  input logic clk,
  input logic rstN,
  input logic bitEn,
  input logic startPulse,
  input logic serOut,
  input logic busy,
  input logic done
);
  assert_quiet_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> serOut);
  assert_hold_no_enable_R7: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> ($stable(serOut) && $stable(done)));
  assert_strobe_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> busy);
  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (!busy || startPulse || $past(startPulse)) && serOut);
  assert_busy_fall_enabled_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(bitEn));
endmodule

bind feac_tx_seq feac_tx_seq_checker uChk (
  .clk(clk), .rstN(rstN), .bitEn(bitEn), .startPulse(startPulse),
  .serOut(serOut), .busy(busy), .done(done)
);

// File: tb/tb_feac_tx_seq.sv
module tb_feac_tx_seq;
  localparam int REPS = 10;
  localparam int WDOG = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitEn = 1'b0;
  logic [5:0] codeA = '0, codeB = '0;
  logic [1:0] modeSel = '0;
  logic startPulse = 1'b0;
  logic serOut, busy, done;

  int vectors = 0, fails = 0, cyc = 0, enDiv = 1;
  string curReq = "R1";

  feac_tx_seq dut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .codeA(codeA), .codeB(codeB),
    .modeSel(modeSel), .startPulse(startPulse), .serOut(serOut),
    .busy(busy), .done(done)
  );

  always #5 clk = ~clk;

  // reference model
  int  q[$];
  int  leftA = 0, leftB = 0;
  bit  mCont = 0, mActive = 0, mPend = 0, mDone = 0, mOut = 1;

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete(); leftA = 0; leftB = 0;
      mCont = 0; mActive = 0; mPend = 0; mDone = 0; mOut = 1;
    end else begin
      if (bitEn) begin
        if (q.size() == 0) begin
          if (mPend) begin
            mPend = 0; mDone = 0; leftA = 0; leftB = 0; mCont = 0; mActive = 1;
            case (modeSel)
              2'd1: leftA = REPS;
              2'd2: begin leftA = REPS; leftB = REPS; end
              2'd3: mCont = 1;
              default: mActive = 0;
            endcase
          end
          if (mActive) begin
            logic [5:0] c;
            if (mCont || leftA > 0) begin c = codeA; if (!mCont) leftA--; end
            else begin c = codeB; leftB--; end
            q.push_back(0);
            for (int i = 0; i < 6; i++) q.push_back(int'(c[i]));
            q.push_back(0);
            for (int i = 0; i < 8; i++) q.push_back(1);
          end
        end
        if (q.size() > 0) begin
          mOut = q.pop_front()[0];
          if (q.size() == 0 && mActive) begin
            if (mCont) begin
              if (modeSel != 2'd3) mActive = 0;
            end else if (leftA == 0 && leftB == 0) begin
              mActive = 0; mDone = 1;
            end
          end
        end else mOut = 1;
      end
      if (startPulse) mPend = 1;
    end
  end

  task automatic check(input string req, input string sig, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, sig, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    bitEn = (enDiv > 0) && (cyc % enDiv == 0);
    if (rstN) begin
      check(curReq, "serOut", int'(serOut), int'(mOut));
      check("R10", "busy", int'(busy), int'(mPend | mActive));
      check(curReq, "done", int'(done), int'(mDone));
    end
    if (cyc > WDOG) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic pulse(input logic [1:0] m);
    @(negedge clk); modeSel = m; startPulse = 1'b1;
    @(negedge clk); startPulse = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 20000 && (busy || startPulse); i++) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    curReq = "R1";
    check("R1", "serOut reset", int'(serOut), 1);
    check("R1", "busy reset", int'(busy), 0);
    check("R1", "done reset", int'(done), 0);

    curReq = "R2"; enDiv = 1;
    pulse(2'd0); repeat (60) @(negedge clk);
    check("R2", "serOut idle", int'(serOut), 1);

    curReq = "R4"; codeA = 6'b101100;      // R3 format carried by each word
    pulse(2'd1); waitIdle();
    check("R4", "done after single", int'(done), 1);

    curReq = "R5"; enDiv = 2; codeA = 6'h15; codeB = 6'h2A;
    pulse(2'd2);
    repeat (101) @(negedge clk);
    modeSel = 2'd1;                         // R8: ignored during burst
    waitIdle();
    check("R5", "done after dual", int'(done), 1);

    curReq = "R9"; enDiv = 1; codeA = 6'h3C;
    pulse(2'd1); repeat (5) @(negedge clk);
    codeA = 6'h03; repeat (37) @(negedge clk);
    codeA = 6'h11; waitIdle();

    curReq = "R6"; enDiv = 3; codeA = 6'h27;
    pulse(2'd3); repeat (1003) @(negedge clk);
    modeSel = 2'd0; waitIdle();
    check("R6", "done after continuous", int'(done), 0);

    curReq = "R7"; enDiv = 5; codeA = 6'h09;
    pulse(2'd1); waitIdle();

    curReq = "R8"; enDiv = 1; codeA = 6'h1E; codeB = 6'h21;
    pulse(2'd1); repeat (37) @(negedge clk);
    pulse(2'd2); waitIdle();
    pulse(2'd3); repeat (50) @(negedge clk);
    pulse(2'd0); waitIdle();

    curReq = "R10"; enDiv = 4; codeA = 6'h2D; codeB = 6'h12;
    pulse(2'd2); waitIdle();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule